// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, one frame at a time, whether an incoming Ethernet frame should be kept, using only its 48-bit destination address. Software loads a small table of station addresses, a per-entry enable mask and a five-bit acceptance mode through a single-cycle register write port. The receive path presents each destination address with a one-cycle strobe, and one clock later the block returns a keep or drop verdict, a hit flag and the index of the table entry that matched.

The verdict is the OR of two terms. The first is a class term: plain unicast, group (multicast) and all-ones (broadcast) addresses each have their own unconditional accept bit. The second is a table term: when table comparison is turned on, a match against any enabled entry counts for the frame, and an invert bit turns the table into a block list instead. In the usual setup only compare-enable and broadcast-accept are set. Setting all three class bits plus compare-enable gives promiscuous reception.

Top module: `dst_addr_filter`

## Requirements
- R1: Mode register (write offset 0x00) bit 0 set accepts every frame whose destination has bit 40 (least significant bit of the first address byte) clear.
- R2: Mode bit 1 set accepts every frame whose destination has bit 40 set, except the all-ones address.
- R3: Mode bit 2 set accepts the all-ones destination address. Mode bit 1 alone does not accept it.
- R4: Mode bit 4 enables table comparison: the frame is accepted when an enabled entry equals the destination. When bit 4 is clear the table has no effect, and res_hit and res_index are 0.
- R5: Mode bit 3 inverts the table term when bit 4 is set: a matching frame gets no acceptance from the table, and a non-matching frame does. The class bits of R1 to R3 still accept regardless.
- R6: Entry i has a high word at offset 0x08+8*i, with data bits 31:0 holding destination bits 47:16 (first address byte in bits 31:24), and a low word at offset 0x0C+8*i, with data bits 31:16 holding destination bits 15:0. Bits 15:0 of a low-word write are ignored.
- R7: The enable register (offset 0x04) bit i gates entry i. A disabled entry never matches.
- R8: When several enabled entries match, res_index reports the lowest-numbered one. With no hit, res_index is 0.
- R9: res_valid is high exactly one cycle after each cycle with frm_valid high. res_accept, res_hit and res_index are 0 whenever res_valid is low.
- R10: A register write affects frames presented in later cycles. A frame presented in the same cycle as the write is judged with the previous contents.
- R11: After reset, every register is zero, so all frames are rejected and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| frm_valid | input | 1 | Destination address present this cycle |
| frm_dst | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Verdict valid (one cycle after frm_valid) |
| res_accept | output | 1 | Frame is kept |
| res_hit | output | 1 | An enabled table entry matched with comparison on |
| res_index | output | 4 | Lowest matching entry index |

## Verification
The hardest case to reach from the ports is a frame that several enabled entries match, combined with every mode setting, because the priority encoder and the invert bit interact only when the table holds duplicate addresses. The bench loads sixteen entries with one duplicated pair, one disabled entry and one group address. It then sweeps all 32 mode values over every stored address plus unicast, multicast and broadcast misses. A frame presented in the same cycle as a rewrite of the entry it matches exercises the write-ordering rule.

// File: rtl/dstf_pkg.sv
package dstf_pkg;

    localparam int MAC_W = 48;
    localparam int MODE_REG_OFS = 8'h00;
    localparam int EN_REG_OFS = 8'h04;
    localparam int ENT_BASE_OFS = 8'h08;
    localparam int ENT_STRIDE = 8;

    typedef logic [MAC_W-1:0] mac_t;

    // packed MSB first: bit4 cmp_en ... bit0 uc_ok
    typedef struct packed {
        logic cmp_en;
        logic invert;
        logic bc_ok;
        logic mc_ok;
        logic uc_ok;
    } mode_t;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2
    } cls_e;

    function automatic cls_e classify(input mac_t a);
        if (&a)
            return CLS_BCAST;
        else if (a[MAC_W-8])
            return CLS_MULTI;
        else
            return CLS_UNI;
    endfunction

endpackage

// File: rtl/dstf_regs.sv
module dstf_regs
    import dstf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int REG_AW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    output mode_t                 mode_q,
    output logic [N_ENT-1:0]      en_q,
    output logic [N_ENT-1:0][MAC_W-1:0] tbl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_AW'(MODE_REG_OFS))
                mode_q <= wr_data[$bits(mode_t)-1:0];
            if (wr_addr == REG_AW'(EN_REG_OFS))
                en_q <= wr_data[N_ENT-1:0];
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        localparam int HI_OFS = ENT_BASE_OFS + ENT_STRIDE * g;
        localparam int LO_OFS = HI_OFS + 4;
        always_ff @(posedge clk) begin
            if (rst)
                tbl_q[g] <= '0;
            else if (wr_en && wr_addr == REG_AW'(HI_OFS))
                tbl_q[g][MAC_W-1:16] <= wr_data;
            else if (wr_en && wr_addr == REG_AW'(LO_OFS))
                tbl_q[g][15:0] <= wr_data[31:16];
        end
    end

endmodule

// File: rtl/dstf_cam.sv
module dstf_cam
    import dstf_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  mac_t                        dst,
    input  logic [N_ENT-1:0]            en,
    input  logic [N_ENT-1:0][MAC_W-1:0] tbl,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);

    logic [N_ENT-1:0] match;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = en[g] && (tbl[g] == dst);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i])
                idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dstf_decide.sv
module dstf_decide
    import dstf_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_valid,
    input  mac_t             dst,
    input  mode_t            mode,
    input  logic             raw_hit,
    input  logic [IDX_W-1:0] raw_idx,
    output logic             res_valid,
    output logic             res_accept,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_index
);

    cls_e             cls;
    logic             cls_ok;
    logic             tbl_term;
    logic             hit_g;
    logic [IDX_W-1:0] idx_g;

    always_comb begin
        cls = classify(dst);
        unique case (cls)
            CLS_UNI:   cls_ok = mode.uc_ok;
            CLS_MULTI: cls_ok = mode.mc_ok;
            CLS_BCAST: cls_ok = mode.bc_ok;
            default:   cls_ok = 1'b0;
        endcase
        tbl_term = mode.cmp_en && (raw_hit ^ mode.invert);
        hit_g    = mode.cmp_en && raw_hit;
        idx_g    = hit_g ? raw_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !frm_valid) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_hit    <= 1'b0;
            res_index  <= '0;
        end else begin
            res_valid  <= 1'b1;
            res_accept <= cls_ok || tbl_term;
            res_hit    <= hit_g;
            res_index  <= idx_g;
        end
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import dstf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int REG_AW = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frm_valid,
    input  logic [47:0]       frm_dst,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_index
);

    mode_t                       mode_q;
    logic [N_ENT-1:0]            en_q;
    logic [N_ENT-1:0][MAC_W-1:0] tbl_q;
    logic                        raw_hit;
    logic [IDX_W-1:0]            raw_idx;

    dstf_regs #(.N_ENT(N_ENT), .REG_AW(REG_AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .en_q    (en_q),
        .tbl_q   (tbl_q)
    );

    dstf_cam #(.N_ENT(N_ENT)) u_cam (
        .dst (frm_dst),
        .en  (en_q),
        .tbl (tbl_q),
        .hit (raw_hit),
        .idx (raw_idx)
    );

    dstf_decide #(.N_ENT(N_ENT)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .frm_valid  (frm_valid),
        .dst        (frm_dst),
        .mode       (mode_q),
        .raw_hit    (raw_hit),
        .raw_idx    (raw_idx),
        .res_valid  (res_valid),
        .res_accept (res_accept),
        .res_hit    (res_hit),
        .res_index  (res_index)
    );

endmodule

// File: rtl/dstf_checker.sv
module dstf_checker #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_valid,
    input logic [47:0]      frm_dst,
    input logic             res_valid,
    input logic             res_accept,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_index,
    input logic [4:0]       mode_q,
    input logic [N_ENT-1:0] en_q
);

    AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_accept && !res_hit && res_index == '0)); // R9

    AST_BCAST_KEPT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(&frm_dst) && $past(mode_q[2])) |-> res_accept); // R3

    AST_UNI_ALL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(frm_dst[40]) && $past(mode_q[0])) |-> res_accept); // R1

    AST_NO_CMP_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(mode_q[4])) |-> (!res_hit && res_index == '0)); // R4

    AST_HIT_ON_ENABLED: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> ((($past(en_q) >> res_index) & N_ENT'(1)) != '0)); // R7

    AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> res_index == '0); // R8

endmodule

bind dst_addr_filter dstf_checker #(.N_ENT(N_ENT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_valid  (frm_valid),
    .frm_dst    (frm_dst),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_hit    (res_hit),
    .res_index  (res_index),
    .mode_q     (mode_q),
    .en_q       (en_q)
);

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dst = '0;
    logic        res_valid, res_accept, res_hit;
    logic [3:0]  res_index;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    // bench mirror of what was written
    logic [47:0] m_tbl [16];
    logic [15:0] m_en = '0;
    logic [4:0]  m_mode = '0;

    always #10 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frm_valid(frm_valid), .frm_dst(frm_dst), .res_valid(res_valid),
        .res_accept(res_accept), .res_hit(res_hit), .res_index(res_index)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_entry(input int i, input logic [47:0] mac, input logic [15:0] junk);
        reg_wr(8'(8 + 8 * i), mac[47:16]);
        reg_wr(8'(12 + 8 * i), {mac[15:0], junk});
        m_tbl[i] = mac;
    endtask

    task automatic set_mode(input logic [4:0] m);
        reg_wr(8'h00, {27'd0, m});
        m_mode = m;
    endtask

    task automatic set_en(input logic [15:0] e);
        reg_wr(8'h04, {16'd0, e});
        m_en = e;
    endtask

    // present one frame; outputs are checked at the following negedge
    task automatic present(input logic [47:0] d);
        @(negedge clk);
        frm_valid = 1'b1; frm_dst = d;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic model(input logic [47:0] d, output logic acc, output logic hit,
                         output logic [3:0] idx);
        logic found = 1'b0;
        logic [3:0] fi = '0;
        logic grp, bc, clsok, cmp;
        for (int i = 0; i < 16; i++) begin
            if (!found && m_en[i] && m_tbl[i] == d) begin
                found = 1'b1; fi = 4'(i);
            end
        end
        grp = d[40];
        bc = &d;
        cmp = m_mode[4];
        clsok = (!grp && m_mode[0]) || (grp && !bc && m_mode[1]) || (bc && m_mode[2]);
        acc = clsok || (cmp && (found ^ m_mode[3]));
        hit = cmp && found;
        idx = hit ? fi : 4'd0;
    endtask

    task automatic probe(input string tag, input logic [47:0] d);
        logic ea, eh;
        logic [3:0] ei;
        model(d, ea, eh, ei);
        present(d);
        chk({tag, " valid"}, {7'd0, res_valid}, 8'd1);
        chk({tag, " accept"}, {7'd0, res_accept}, {7'd0, ea});
        chk({tag, " hit"}, {7'd0, res_hit}, {7'd0, eh});
        chk({tag, " index"}, {4'd0, res_index}, {4'd0, ei});
    endtask

    function automatic logic [47:0] ent_mac(input int i);
        return {8'h02, 8'(8'h10 + i), 32'hA5C3_0000 + 32'(i * 17)};
    endfunction

    localparam logic [47:0] MISS_UNI = 48'h0200_DEAD_BEEF;
    localparam logic [47:0] MISS_MC  = 48'h0100_5E00_0001;
    localparam logic [47:0] BCAST    = 48'hFFFF_FFFF_FFFF;

    initial begin
        for (int i = 0; i < 16; i++) m_tbl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: quiet outputs after reset, all frames rejected
        chk("R11 valid after reset", {7'd0, res_valid}, 8'd0);
        chk("R11 accept after reset", {7'd0, res_accept}, 8'd0);
        present(BCAST);
        chk("R11 bcast rejected", {7'd0, res_accept}, 8'd0);
        present(MISS_UNI);
        chk("R11 unicast rejected", {7'd0, res_accept}, 8'd0);

        // R6: load table, junk in unused low bits
        for (int i = 0; i < 16; i++) set_entry(i, ent_mac(i), 16'(16'hF0F0 ^ i));
        set_entry(12, ent_mac(3), 16'hFFFF);     // duplicate for R8
        set_entry(15, 48'h0300_1234_5678, 16'h1111); // group address in table
        set_en(16'hFF7F);                        // entry 7 off, R7

        // R1..R5 full mode sweep
        for (int m = 0; m < 32; m++) begin
            set_mode(5'(m));
            for (int i = 0; i < 16; i++) probe("R4 R5 sweep entry", m_tbl[i]);
            probe("R1 sweep unicast miss", MISS_UNI);
            probe("R2 sweep multicast miss", MISS_MC);
            probe("R3 sweep broadcast", BCAST);
        end

        // R3: multicast bit alone leaves broadcast out
        set_mode(5'b00010);
        present(BCAST);
        chk("R3 mc bit not bcast", {7'd0, res_accept}, 8'd0);
        present(MISS_MC);
        chk("R2 mc accepted", {7'd0, res_accept}, 8'd1);
        set_mode(5'b00001);
        present(MISS_UNI);
        chk("R1 uc accepted", {7'd0, res_accept}, 8'd1);

        // R4 and R6: normal mode, table hit despite junk low bits
        set_mode(5'b10100);
        present(ent_mac(9));
        chk("R6 hit with junk low bits", {7'd0, res_hit}, 8'd1);
        chk("R6 index", {4'd0, res_index}, 8'd9);
        // R7: disabled entry
        present(ent_mac(7));
        chk("R7 disabled no hit", {7'd0, res_hit}, 8'd0);
        chk("R7 disabled rejected", {7'd0, res_accept}, 8'd0);
        // R8: priority with duplicate
        present(ent_mac(3));
        chk("R8 lowest index", {4'd0, res_index}, 8'd3);
        set_en(16'hFF77);
        present(ent_mac(3));
        chk("R8 next duplicate", {4'd0, res_index}, 8'd12);
        // R9: no result without strobe
        @(negedge clk);
        chk("R9 idle no valid", {7'd0, res_valid}, 8'd0);
        // R5: invert blocks a match
        set_mode(5'b11000);
        present(ent_mac(0));
        chk("R5 inverted match rejected", {7'd0, res_accept}, 8'd0);
        present(MISS_UNI);
        chk("R5 inverted miss accepted", {7'd0, res_accept}, 8'd1);

        // R10: rewrite entry 0 in the same cycle as a frame for its old value
        set_mode(5'b10000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h0A0B_0C0D;
        frm_valid = 1'b1; frm_dst = ent_mac(0);
        @(negedge clk);
        wr_en = 1'b0; frm_valid = 1'b0;
        chk("R10 same-cycle uses old", {7'd0, res_hit}, 8'd1);
        present(ent_mac(0));
        chk("R10 later uses new", {7'd0, res_hit}, 8'd0);
        present({32'h0A0B_0C0D, ent_mac(0)[15:0]});
        chk("R10 new value hits", {4'd0, res_index}, 8'd0);
        chk("R10 new value hit flag", {7'd0, res_hit}, 8'd1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule